// File: doc/BRIEF.md
# JTAG Debug Transport Register Block

This block sits behind the instruction decode of a JTAG TAP controller and provides three data registers on the test clock: a fixed identification word, a control/status word and a debug-bus access word. The TAP supplies the current instruction and one-cycle Capture-DR, Shift-DR and Update-DR strobes. The block handles the capture, the LSB-first shifting through TDI/TDO and the update of whichever register is selected. Any instruction the block does not decode behaves as a one-bit register.

On Update-DR of the access register, a read or write operation becomes a request on a valid/ready channel toward a debug module. The module answers later on a separate response channel. The outcome (address, returned data and a status code) only shows up in the next Capture-DR of the access register, so a debugger always reads one scan behind its requests.

A transaction engine holds the bus request in flight. It uses three states:
- `S_IDLE` moves to `S_ISSUE` when an accepted read or write is updated.
- `S_ISSUE` moves to `S_AWAIT` when the request is accepted by ready.
- `S_AWAIT` moves back to `S_IDLE` when a response arrives.

A hard reset forces `S_IDLE` from any state. Failure and busy conditions are sticky. While either one is set, all further access-register updates are ignored until the debugger clears the status through the control/status register.

Top module: `dbg_transport`

## Requirements
- R1: With instruction 0x01 selected, Capture-DR loads a 32-bit word with bit 0 = 1, bits 11:1 = manufacturer code, bits 27:12 = part number and bits 31:28 = version, all set by parameters. Bit 0 is the first bit out on TDO.
- R2: With instruction 0x10 selected, Capture-DR loads a 32-bit word laid out as follows; all other bits read 0:
  - bits 3:0 = 1
  - bits 9:4 = address width ABITS
  - bits 11:10 = current sticky status
  - bits 14:12 = recommended idle-cycle count
- R3: With instruction 0x11 selected, the register is ABITS+34 bits wide: bits 1:0 op/status, bits 33:2 data, bits ABITS+33:34 address. After reset its capture reads all zero.
- R4: On Update-DR of the access register with op 1 (read) or 2 (write), no sticky status and no transaction in flight, the block raises req_valid with the scanned address, data and op. It holds all of them unchanged until req_ready.
- R5: When a response arrives, its data and the request's address are kept. The next access-register capture returns them, with status 0 if the response code was 0.
- R6: Op 0 (no-op) and op 3 (reserved) issue no request and never set busy or failure.
- R7: A nonzero response code sets sticky status 2 (failed). While any sticky status is set, access-register updates issue nothing, and the status is reported in the op field and in bits 11:10 of the control/status word.
- R8: A read or write update that arrives while a transaction is in flight sets sticky status 3 (busy) and is dropped.
- R9: An Update-DR of the control/status register with bit 16 = 1 clears the sticky status. Results are not otherwise disturbed.
- R10: An Update-DR of the control/status register with bit 17 = 1 returns the engine to S_IDLE, drops req_valid, clears the sticky status and discards any response to the abandoned transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir | input | 5 | Current instruction from the TAP |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| update_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (LSB of the selected register) |
| req_valid | output | 1 | Bus request valid |
| req_ready | input | 1 | Bus request accepted |
| req_addr | output | ABITS | Request address |
| req_data | output | 32 | Request write data |
| req_op | output | 2 | Request op, 1 = read, 2 = write |
| rsp_valid | input | 1 | Response valid |
| rsp_data | input | 32 | Response data |
| rsp_resp | input | 2 | Response code, 0 = success |

## Verification
The bench builds the block with ABITS = 7, which gives a 41-bit access register, and with a recommended idle count of 1. The bench model of the debug module has a latency that can be changed between scans. A zero latency lets the result of every scan settle before the next capture, which exposes the one-scan-late result path. A 100-cycle latency keeps a transaction in flight across several whole scans. That makes both the busy status and a hard reset during an outstanding transaction reachable, including a stale response that arrives while a new request is still waiting for ready.

// File: rtl/dxp_pkg.sv
package dxp_pkg;

    localparam int IR_W = 5;

    localparam logic [IR_W-1:0] IR_IDENT = 5'h01;
    localparam logic [IR_W-1:0] IR_CTRL  = 5'h10;
    localparam logic [IR_W-1:0] IR_BUS   = 5'h11;

    localparam logic [1:0] OP_NOP = 2'd0;
    localparam logic [1:0] OP_RD  = 2'd1;
    localparam logic [1:0] OP_WR  = 2'd2;
    localparam logic [1:0] OP_RSV = 2'd3;

    localparam logic [1:0] ST_OK   = 2'd0;
    localparam logic [1:0] ST_FAIL = 2'd2;
    localparam logic [1:0] ST_BUSY = 2'd3;

    localparam int CLR_BIT  = 16;
    localparam int HRST_BIT = 17;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_AWAIT = 2'd2
    } xact_state_t;

endpackage

// File: rtl/dxp_scan.sv
module dxp_scan
    import dxp_pkg::*;
#(
    parameter int ABITS = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IR_W-1:0]     ir,
    input  logic                capture_dr,
    input  logic                shift_dr,
    input  logic                update_dr,
    input  logic                tdi,
    input  logic [31:0]         id_word,
    input  logic [31:0]         ctrl_word,
    input  logic [ABITS+33:0]   bus_word,
    output logic                tdo,
    output logic                upd_bus,
    output logic                upd_ctrl,
    output logic [ABITS+33:0]   scan_q
);

    localparam int W  = ABITS + 34;
    localparam int IW = $clog2(W);

    logic [IW-1:0] top_idx;
    logic [W-1:0]  cap_val;
    logic [W-1:0]  shf_val;

    always_comb begin
        unique case (ir)
            IR_IDENT: begin
                top_idx = IW'(31);
                cap_val = {{(W-32){1'b0}}, id_word};
            end
            IR_CTRL: begin
                top_idx = IW'(31);
                cap_val = {{(W-32){1'b0}}, ctrl_word};
            end
            IR_BUS: begin
                top_idx = IW'(W-1);
                cap_val = bus_word;
            end
            default: begin
                top_idx = '0;
                cap_val = '0;
            end
        endcase
    end

    always_comb begin
        shf_val          = scan_q >> 1;
        shf_val[top_idx] = tdi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            scan_q <= '0;
        else if (capture_dr)
            scan_q <= cap_val;
        else if (shift_dr)
            scan_q <= shf_val;
    end

    assign tdo      = scan_q[0];
    assign upd_bus  = update_dr && (ir == IR_BUS);
    assign upd_ctrl = update_dr && (ir == IR_CTRL);

endmodule

// File: rtl/dxp_engine.sv
module dxp_engine
    import dxp_pkg::*;
#(
    parameter int ABITS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_bus,
    input  logic [1:0]        bus_op,
    input  logic [31:0]       bus_data,
    input  logic [ABITS-1:0]  bus_addr,
    input  logic              upd_ctrl,
    input  logic              clr_bit,
    input  logic              hrst_bit,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic [31:0]       rsp_data,
    input  logic [1:0]        rsp_resp,
    output logic              req_valid,
    output logic [ABITS-1:0]  req_addr,
    output logic [31:0]       req_data,
    output logic [1:0]        req_op,
    output logic [1:0]        sticky,
    output logic [ABITS-1:0]  res_addr,
    output logic [31:0]       res_data,
    output xact_state_t       state
);

    xact_state_t state_nxt;
    logic        real_op;
    logic        start;
    logic        busy_hit;
    logic        hard;
    logic        clear;
    logic        done;

    assign real_op  = (bus_op == OP_RD) || (bus_op == OP_WR);
    assign start    = upd_bus && real_op && (sticky == ST_OK) && (state == S_IDLE);
    assign busy_hit = upd_bus && real_op && (sticky == ST_OK) && (state != S_IDLE);
    assign hard     = upd_ctrl && hrst_bit;
    assign clear    = upd_ctrl && (clr_bit || hrst_bit);
    assign done     = (state == S_AWAIT) && rsp_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else if (hard)
            state <= S_IDLE;
        else
            state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  if (start)     state_nxt = S_ISSUE;
            S_ISSUE: if (req_ready) state_nxt = S_AWAIT;
            S_AWAIT: if (rsp_valid) state_nxt = S_IDLE;
            default:                state_nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_valid = (state == S_ISSUE);
    end

    // request latch, results and sticky status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_addr <= '0;
            req_data <= '0;
            req_op   <= OP_NOP;
            res_addr <= '0;
            res_data <= '0;
            sticky   <= ST_OK;
        end else begin
            if (start) begin
                req_addr <= bus_addr;
                req_data <= bus_data;
                req_op   <= bus_op;
            end
            if (done && !hard) begin
                res_addr <= req_addr;
                res_data <= rsp_data;
            end
            if (clear)
                sticky <= ST_OK;
            else if (sticky == ST_OK) begin
                if (busy_hit)
                    sticky <= ST_BUSY;
                else if (done && (rsp_resp != ST_OK))
                    sticky <= ST_FAIL;
            end
        end
    end

endmodule

// File: rtl/dbg_transport.sv
module dbg_transport
    import dxp_pkg::*;
#(
    parameter int          ABITS     = 7,
    parameter logic [3:0]  ID_VER    = 4'h1,
    parameter logic [15:0] ID_PART   = 16'hD0B1,
    parameter logic [10:0] ID_MFR    = 11'h2A5,
    parameter logic [2:0]  IDLE_HINT = 3'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        ir,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ABITS-1:0]  req_addr,
    output logic [31:0]       req_data,
    output logic [1:0]        req_op,
    input  logic              rsp_valid,
    input  logic [31:0]       rsp_data,
    input  logic [1:0]        rsp_resp
);

    localparam int         W       = ABITS + 34;
    localparam logic [5:0] ABITS_F = 6'(ABITS);

    logic [W-1:0]     scan_q;
    logic             upd_bus;
    logic             upd_ctrl;
    logic [1:0]       sticky;
    logic [ABITS-1:0] res_addr;
    logic [31:0]      res_data;
    xact_state_t      state;
    logic [31:0]      id_word;
    logic [31:0]      ctrl_word;
    logic [W-1:0]     bus_word;

    assign id_word   = {ID_VER, ID_PART, ID_MFR, 1'b1};
    assign ctrl_word = {14'd0, 1'b0, 1'b0, 1'b0, IDLE_HINT, sticky, ABITS_F, 4'd1};
    assign bus_word  = {res_addr, res_data, sticky};

    dxp_scan #(.ABITS(ABITS)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .ir         (ir),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdi        (tdi),
        .id_word    (id_word),
        .ctrl_word  (ctrl_word),
        .bus_word   (bus_word),
        .tdo        (tdo),
        .upd_bus    (upd_bus),
        .upd_ctrl   (upd_ctrl),
        .scan_q     (scan_q)
    );

    dxp_engine #(.ABITS(ABITS)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_bus   (upd_bus),
        .bus_op    (scan_q[1:0]),
        .bus_data  (scan_q[33:2]),
        .bus_addr  (scan_q[W-1:34]),
        .upd_ctrl  (upd_ctrl),
        .clr_bit   (scan_q[CLR_BIT]),
        .hrst_bit  (scan_q[HRST_BIT]),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_resp  (rsp_resp),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .req_op    (req_op),
        .sticky    (sticky),
        .res_addr  (res_addr),
        .res_data  (res_data),
        .state     (state)
    );

endmodule

// File: rtl/dbg_transport_chk.sv
module dbg_transport_chk
    import dxp_pkg::*;
#(
    parameter int ABITS = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_bus,
    input logic              upd_ctrl,
    input logic [ABITS+33:0] scan_q,
    input logic [1:0]        sticky,
    input xact_state_t       state,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ABITS-1:0]  req_addr,
    input logic [31:0]       req_data,
    input logic [1:0]        req_op
);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !(upd_ctrl && scan_q[HRST_BIT]))
        |=> (req_valid && $stable(req_addr) && $stable(req_data) && $stable(req_op)));

    // R4
    req_op_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_op == OP_RD || req_op == OP_WR));

    // R6
    nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_bus && state == S_IDLE && (scan_q[1:0] == OP_NOP || scan_q[1:0] == OP_RSV))
        |=> !req_valid);

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky != ST_OK && !upd_ctrl) |=> $stable(sticky));

    // R7
    no_issue_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky != ST_OK && state == S_IDLE) |=> (state == S_IDLE));

    // R8
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_bus && sticky == ST_OK && state != S_IDLE
         && (scan_q[1:0] == OP_RD || scan_q[1:0] == OP_WR))
        |=> (sticky == ST_BUSY));

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_ctrl && scan_q[CLR_BIT]) |=> (sticky == ST_OK));

    // R10
    hard_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_ctrl && scan_q[HRST_BIT]) |=> (state == S_IDLE && !req_valid && sticky == ST_OK));

endmodule

bind dbg_transport dbg_transport_chk #(.ABITS(ABITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_bus   (upd_bus),
    .upd_ctrl  (upd_ctrl),
    .scan_q    (scan_q),
    .sticky    (sticky),
    .state     (state),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .req_op    (req_op)
);

// File: tb/sim_dbg_transport.sv
`timescale 1ns/1ps
module sim_dbg_transport;

    localparam int ABITS = 7;
    localparam int W     = ABITS + 34;
    localparam logic [3:0]  T_VER  = 4'h1;
    localparam logic [15:0] T_PART = 16'hD0B1;
    localparam logic [10:0] T_MFR  = 11'h2A5;
    localparam logic [2:0]  T_IDLE = 3'd1;
    localparam logic [4:0]  I_ID   = 5'h01;
    localparam logic [4:0]  I_CS   = 5'h10;
    localparam logic [4:0]  I_BUS  = 5'h11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [4:0]       ir = I_ID;
    logic             capture_dr = 1'b0;
    logic             shift_dr = 1'b0;
    logic             update_dr = 1'b0;
    logic             tdi = 1'b0;
    logic             tdo;
    logic             req_valid;
    logic             req_ready = 1'b0;
    logic [ABITS-1:0] req_addr;
    logic [31:0]      req_data;
    logic [1:0]       req_op;
    logic             rsp_valid = 1'b0;
    logic [31:0]      rsp_data = '0;
    logic [1:0]       rsp_resp = '0;

    always #5 clk = ~clk;

    dbg_transport #(
        .ABITS(ABITS), .ID_VER(T_VER), .ID_PART(T_PART),
        .ID_MFR(T_MFR), .IDLE_HINT(T_IDLE)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ir(ir), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_data(req_data), .req_op(req_op), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_resp(rsp_resp)
    );

    int pass_n = 0;
    int total_n = 0;

    // ---------------- debug module model ----------------
    logic [31:0] mem [0:(1<<ABITS)-1];
    int          lat = 0;
    int          hs_count = 0;
    bit          pend = 0;
    int          cnt = 0;
    logic [31:0] pdata = '0;
    logic [1:0]  presp = '0;

    initial begin
        for (int i = 0; i < (1 << ABITS); i++) mem[i] = 32'hC000_0000 | i;
    end

    always @(negedge clk) begin
        req_ready <= 1'b0;
        rsp_valid <= 1'b0;
        if (!rst_n) begin
            pend = 0;
        end else if (pend) begin
            if (cnt == 0) begin
                rsp_valid <= 1'b1;
                rsp_data  <= pdata;
                rsp_resp  <= presp;
                pend = 0;
            end else begin
                cnt--;
            end
        end else if (req_valid) begin
            req_ready <= 1'b1;
            pend = 1;
            cnt = lat;
            hs_count++;
            if (req_addr == 7'h7F) begin
                pdata = '0;
                presp = 2'd2;
            end else if (req_op == 2'd1) begin
                pdata = mem[req_addr];
                presp = 2'd0;
            end else begin
                mem[req_addr] = req_data;
                pdata = '0;
                presp = 2'd0;
            end
        end
    end

    // ---------------- scoreboard ----------------
    logic [W-1:0] exp_q [$];
    logic [W-1:0] msk_q [$];
    string        tag_q [$];
    logic [W-1:0] got_word;
    event         got_ev;

    initial begin
        forever begin
            logic [W-1:0] e;
            logic [W-1:0] m;
            string        t;
            @(got_ev);
            e = exp_q.pop_front();
            m = msk_q.pop_front();
            t = tag_q.pop_front();
            total_n++;
            if ((got_word & m) === (e & m)) pass_n++;
            else $display("FAIL %s: actual %h expected %h", t, got_word & m, e & m);
        end
    end

    task automatic check_int(input string tag, input int act, input int exp);
        total_n++;
        if (act == exp) pass_n++;
        else $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    endtask

    function automatic logic [W-1:0] bw(input logic [6:0] a, input logic [31:0] d, input logic [1:0] o);
        return {a, d, o};
    endfunction

    function automatic logic [W-1:0] cw(input logic [1:0] st);
        return W'({T_IDLE, st, 6'(ABITS), 4'd1});
    endfunction

    task automatic scan_chk(input logic [4:0] irv, input int len, input logic [W-1:0] din,
                            input int idle, input logic [W-1:0] expv,
                            input logic [W-1:0] mask, input string tag);
        logic [W-1:0] dout = '0;
        exp_q.push_back(expv);
        msk_q.push_back(mask);
        tag_q.push_back(tag);
        @(negedge clk);
        ir = irv;
        capture_dr = 1'b1;
        @(posedge clk);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            capture_dr = 1'b0;
            shift_dr = 1'b1;
            dout[i] = tdo;
            tdi = din[i];
            @(posedge clk);
        end
        @(negedge clk);
        shift_dr = 1'b0;
        update_dr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        update_dr = 1'b0;
        for (int i = 0; i < idle; i++) @(posedge clk);
        got_word = dout;
        ->got_ev;
    endtask

    localparam logic [W-1:0] M32  = W'(32'hFFFF_FFFF);
    localparam logic [W-1:0] MALL = '1;
    localparam logic [W-1:0] MOP  = W'(2'b11);

    initial begin
        #(10 * 150000);
        total_n++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", pass_n, total_n);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1 identification word
        scan_chk(I_ID, 32, '0, 4, W'({T_VER, T_PART, T_MFR, 1'b1}), M32, "R1 ident");
        // R2 control/status word after reset
        scan_chk(I_CS, 32, '0, 4, cw(2'd0), M32, "R2 ctrl reset");
        // R3 reset capture of access register, issue write 5
        scan_chk(I_BUS, W, bw(7'h05, 32'hA5A5_0001, 2'd2), 4, bw(0, 0, 0), MALL, "R3 reset capture");
        // R5 write result seen one scan later, issue read 5
        scan_chk(I_BUS, W, bw(7'h05, 32'h0, 2'd1), 4, bw(7'h05, 0, 0), MALL, "R5 write result");
        // R4 R5 read data one scan late
        scan_chk(I_BUS, W, bw(0, 0, 2'd0), 4, bw(7'h05, 32'hA5A5_0001, 0), MALL, "R5 read result");
        check_int("R4 two requests", hs_count, 2);
        // R6 no-op and reserved op send nothing
        scan_chk(I_BUS, W, bw(7'h05, 32'h1234, 2'd3), 4, bw(7'h05, 32'hA5A5_0001, 0), MALL, "R6 after nop");
        scan_chk(I_BUS, W, bw(0, 0, 2'd0), 4, bw(7'h05, 32'hA5A5_0001, 0), MALL, "R6 after reserved");
        check_int("R6 no request", hs_count, 2);

        // R7 failure response
        scan_chk(I_BUS, W, bw(7'h7F, 0, 2'd1), 4, bw(7'h05, 32'hA5A5_0001, 0), MALL, "R7 pre-fail");
        scan_chk(I_BUS, W, bw(7'h05, 32'h0BAD, 2'd2), 4, bw(7'h7F, 0, 2'd2), MALL, "R7 fail status");
        scan_chk(I_CS, 32, '0, 4, cw(2'd2), M32, "R7 ctrl stat");
        check_int("R7 write ignored", hs_count, 3);
        // R9 clear
        scan_chk(I_CS, 32, W'(1) << 16, 4, cw(2'd2), M32, "R9 clear capture");
        scan_chk(I_BUS, W, bw(7'h05, 0, 2'd1), 4, bw(7'h7F, 0, 2'd0), MALL, "R9 cleared");
        scan_chk(I_BUS, W, bw(0, 0, 2'd0), 4, bw(7'h05, 32'hA5A5_0001, 0), MALL, "R7 data kept");

        // R8 busy
        lat = 100;
        scan_chk(I_BUS, W, bw(7'h09, 0, 2'd1), 0, bw(7'h05, 32'hA5A5_0001, 0), MALL, "R8 issue");
        scan_chk(I_BUS, W, bw(7'h09, 32'h55, 2'd2), 0, bw(7'h05, 32'hA5A5_0001, 0), MALL, "R8 in flight");
        scan_chk(I_BUS, W, bw(0, 0, 2'd0), 0, W'(2'd3), MOP, "R8 busy status");
        scan_chk(I_CS, 32, '0, 200, cw(2'd3), M32, "R8 ctrl stat");
        scan_chk(I_CS, 32, W'(1) << 16, 4, cw(2'd3), M32, "R9 clear busy");
        scan_chk(I_BUS, W, bw(0, 0, 2'd0), 4, bw(7'h09, 32'hC000_0009, 0), MALL, "R8 first read done");
        check_int("R8 dropped write", hs_count, 5);
        check_int("R8 mem unchanged", int'(mem[9]), int'(32'hC000_0009));

        // R10 hard reset
        scan_chk(I_BUS, W, bw(7'h05, 0, 2'd1), 0, bw(7'h09, 32'hC000_0009, 0), MALL, "R10 issue");
        scan_chk(I_CS, 32, W'(1) << 17, 0, cw(2'd0), M32, "R10 ctrl");
        scan_chk(I_BUS, W, bw(7'h0A, 0, 2'd1), 400, bw(7'h09, 32'hC000_0009, 0), MALL, "R10 new issue");
        scan_chk(I_BUS, W, bw(0, 0, 2'd0), 4, bw(7'h0A, 32'hC000_000A, 0), MALL, "R10 fresh result");
        check_int("R10 requests", hs_count, 7);
        lat = 0;

        repeat (4) @(posedge clk);
        $display("%0d/%0d checks passed", pass_n, total_n);
        $finish;
    end

endmodule